// File: doc/BRIEF.md
# USB Host Power-State Controller

This block sequences the power states of a USB host port. Software writes a small power control register: a suspend request, a resume bit, a bus-reset bit, a high-speed negotiation enable, and an enable that lets the PHY drop into low power while the bus is suspended. The block turns these bits into enables for the frame counter, the transaction scheduler and SOF generation. It also issues commands that tell the line logic to drive resume or reset signaling, and a PHY low-power request. A suspend request does not cut traffic at once: the block first lets the scheduler finish the transaction already in flight.

When the attached device signals a wake-up while the bus is suspended, the block leaves suspend. It sets the resume bit in hardware, so that the host takes over driving resume until software clears the bit, and it can raise a one-cycle resume interrupt. During bus reset it requests high-speed negotiation if that is enabled. It then records the outcome reported by a chirp-done/chirp-result pair in a read-only high-speed status bit. All of this is active only in the host role: a session must be running and the role input must select host. Every input and output is a plain level signal; there is no streaming interface.

Top module: `usb_host_pwr_ctl`

## Requirements
- R1: The block is active only while `role_dev` is 0 and `sess_on` is 1. Otherwise every control output is 0. One cycle after the host role begins, the frame, scheduler and SOF enables are 1.
- R2: The register read value has bit 0 = PHY-suspend enable, bit 1 = suspend request, bit 2 = resume, bit 3 = bus reset, bit 4 = high-speed status and bit 5 = negotiation enable. Bits 6 and up read 0. Bit 4 cannot be written. A write shows in the read value on the next cycle, and outputs respond one cycle after that.
- R3: A suspend request received while `xfer_busy` is 1 lowers the scheduler and SOF enables but keeps the frame enable. All three enables go to 0 only in the cycle after `xfer_busy` is seen low.
- R4: `phy_lowpwr` is 1 only while suspended with bit 0 set.
- R5: While the resume bit is 1, `drive_resume` is 1 and the three enables are 0. Clearing the bit restores the enables.
- R6: A `bus_resume_det` pulse while suspended sets the resume bit, clears the suspend request, drops `phy_lowpwr` and raises `drive_resume` on the next cycle. It also gives a one-cycle `resume_irq` if `irq_resume_en` is 1. Outside suspend the pulse has no effect.
- R7: A software write in the same cycle as a wake-up decides the resume and suspend bits.
- R8: The reset bit overrides suspend and resume: `drive_reset` is 1, `drive_resume` and `phy_lowpwr` are 0, and a pending suspend request is cleared.
- R9: During reset, `hs_negotiate` is 1 while bit 5 is set and no chirp result has arrived. `chirp_done` loads `chirp_hs` into bit 4 and ends the request.
- R10: Bit 4 is cleared when a reset begins.
- R11: Clearing the reset bit restores the three enables one cycle after the register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| role_dev | input | 1 | 1 selects the peripheral role, 0 the host role |
| sess_on | input | 1 | Session running |
| pwr_wr | input | 1 | Write strobe for the power register |
| pwr_wdata | input | 8 | Power register write data |
| pwr_rdata | output | 8 | Power register read value |
| irq_resume_en | input | 1 | Enables the resume interrupt |
| xfer_busy | input | 1 | A transaction is in progress |
| bus_resume_det | input | 1 | Resume signaling detected on the bus |
| chirp_done | input | 1 | High-speed negotiation finished |
| chirp_hs | input | 1 | Negotiation selected high speed |
| frame_en | output | 1 | Frame counter enable |
| sched_en | output | 1 | Transaction scheduler enable |
| sof_en | output | 1 | SOF generation enable |
| drive_resume | output | 1 | Drive resume signaling |
| drive_reset | output | 1 | Drive reset signaling |
| phy_lowpwr | output | 1 | PHY low-power request |
| hs_negotiate | output | 1 | Request high-speed negotiation |
| resume_irq | output | 1 | One-cycle resume interrupt |

## Verification
A register write appears in the read value one cycle after it is sampled, and the control outputs follow one cycle after that. Role, session, busy and wake-up inputs change the outputs one cycle after they are sampled, and the interrupt falls again one cycle later. Each stimulus task queues its expected output word stamped with the cycle on which it becomes due, counted from the edge that samples the stimulus. A monitor compares each queued word at the falling edge of exactly that cycle, and it also reports any word whose cycle has already passed.

// File: rtl/usb_pwr_pkg.sv
package usb_pwr_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_RUN, ST_DRAIN, ST_SUSP, ST_RESUME, ST_RESET
  } pwr_st_e;

  localparam int PB_PHYS = 0;
  localparam int PB_SUSP = 1;
  localparam int PB_RES  = 2;
  localparam int PB_RST  = 3;
  localparam int PB_HS   = 4;
  localparam int PB_HSEN = 5;
  localparam int PB_USED = 6;
endpackage

// File: rtl/usb_pwr_regs.sv
module usb_pwr_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wd_phys,
  input  logic wd_susp,
  input  logic wd_res,
  input  logic wd_rst,
  input  logic wd_hsen,
  input  logic wake,
  input  logic rst_hold,
  output logic q_phys,
  output logic q_susp,
  output logic q_res,
  output logic q_rst,
  output logic q_hsen
);
  logic n_susp, n_res;

  always_comb begin
    n_susp = (wr ? wd_susp : q_susp) & ~rst_hold & ~(wake & ~wr);
    n_res  = wr ? wd_res : (q_res | wake);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_phys <= 1'b0;
      q_susp <= 1'b0;
      q_res  <= 1'b0;
      q_rst  <= 1'b0;
      q_hsen <= 1'b0;
    end else begin
      if (wr) begin
        q_phys <= wd_phys;
        q_rst  <= wd_rst;
        q_hsen <= wd_hsen;
      end
      q_susp <= n_susp;
      q_res  <= n_res;
    end
  end

  AST_SW_WINS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wd_res) |=> !q_res); // R7
  AST_WAKE_SETS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !wr) |=> (q_res && !q_susp)); // R6
endmodule

// File: rtl/usb_pwr_fsm.sv
module usb_pwr_fsm
  import usb_pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    host,
  input  logic    susp_b,
  input  logic    res_b,
  input  logic    rst_b,
  input  logic    phys_b,
  input  logic    busy,
  input  logic    resume_det,
  input  logic    irq_en,
  output pwr_st_e st,
  output logic    wake,
  output logic    rst_enter,
  output logic    frame_en,
  output logic    sched_en,
  output logic    sof_en,
  output logic    drive_resume,
  output logic    drive_reset,
  output logic    phy_lowpwr,
  output logic    irq
);
  pwr_st_e nxt;

  assign wake = (st == ST_SUSP) && resume_det;

  always_comb begin
    nxt = st;
    if (!host)      nxt = ST_OFF;
    else if (rst_b) nxt = ST_RESET;
    else begin
      case (st)
        ST_OFF:    nxt = ST_RUN;
        ST_RUN:    if (res_b) nxt = ST_RESUME;
                   else if (susp_b) nxt = busy ? ST_DRAIN : ST_SUSP;
        ST_DRAIN:  if (res_b) nxt = ST_RESUME;
                   else if (!susp_b) nxt = ST_RUN;
                   else if (!busy) nxt = ST_SUSP;
        ST_SUSP:   if (wake || res_b) nxt = ST_RESUME;
        ST_RESUME: if (!res_b) nxt = ST_RUN;
        ST_RESET:  nxt = ST_RUN;
        default:   nxt = ST_OFF;
      endcase
    end
  end

  assign rst_enter = (nxt == ST_RESET) && (st != ST_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_OFF;
      irq <= 1'b0;
    end else begin
      st  <= nxt;
      irq <= wake & irq_en;
    end
  end

  always_comb begin
    frame_en     = (st == ST_RUN) || (st == ST_DRAIN);
    sched_en     = (st == ST_RUN);
    sof_en       = (st == ST_RUN);
    drive_resume = (st == ST_RESUME);
    drive_reset  = (st == ST_RESET);
    phy_lowpwr   = (st == ST_SUSP) && phys_b;
  end

  AST_DRAIN_BEFORE_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (host && st == ST_RUN && susp_b && !res_b && !rst_b && busy) |=> (st != ST_SUSP)); // R3
  AST_SUSPEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP) |-> (!sched_en && !sof_en && !frame_en)); // R3
  AST_LINE_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive_reset, drive_resume, phy_lowpwr})); // R8
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (host && rst_b) |=> drive_reset); // R8
endmodule

// File: rtl/usb_pwr_hsneg.sv
module usb_pwr_hsneg (
  input  logic clk,
  input  logic rst_n,
  input  logic in_reset,
  input  logic rst_enter,
  input  logic hsen,
  input  logic done,
  input  logic result,
  output logic negotiate,
  output logic hs_mode
);
  logic neg_done;

  assign negotiate = in_reset & hsen & ~neg_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_done <= 1'b0;
      hs_mode  <= 1'b0;
    end else if (rst_enter) begin
      neg_done <= 1'b0;
      hs_mode  <= 1'b0;
    end else if (negotiate && done) begin
      neg_done <= 1'b1;
      hs_mode  <= result;
    end
  end

  AST_HS_CLEARED_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_enter |=> !hs_mode); // R10
  AST_CHIRP_ENDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (negotiate && done && !rst_enter) |=> (!negotiate && hs_mode == $past(result))); // R9
endmodule

// File: rtl/usb_host_pwr_ctl.sv
module usb_host_pwr_ctl
  import usb_pwr_pkg::*;
#(
  parameter int PWR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             role_dev,
  input  logic             sess_on,
  input  logic             pwr_wr,
  input  logic [PWR_W-1:0] pwr_wdata,
  output logic [PWR_W-1:0] pwr_rdata,
  input  logic             irq_resume_en,
  input  logic             xfer_busy,
  input  logic             bus_resume_det,
  input  logic             chirp_done,
  input  logic             chirp_hs,
  output logic             frame_en,
  output logic             sched_en,
  output logic             sof_en,
  output logic             drive_resume,
  output logic             drive_reset,
  output logic             phy_lowpwr,
  output logic             hs_negotiate,
  output logic             resume_irq
);
  localparam int SPARE_W = PWR_W - PB_USED;

  logic    host, wake, rst_enter;
  logic    q_phys, q_susp, q_res, q_rst, q_hsen, hs_mode;
  pwr_st_e st;
  logic    unused_wbits;

  assign host         = ~role_dev & sess_on;
  assign unused_wbits = ^{pwr_wdata[PWR_W-1:PB_USED], pwr_wdata[PB_HS]};

  usb_pwr_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (pwr_wr),
    .wd_phys  (pwr_wdata[PB_PHYS]),
    .wd_susp  (pwr_wdata[PB_SUSP]),
    .wd_res   (pwr_wdata[PB_RES]),
    .wd_rst   (pwr_wdata[PB_RST]),
    .wd_hsen  (pwr_wdata[PB_HSEN]),
    .wake     (wake),
    .rst_hold (host & q_rst),
    .q_phys   (q_phys),
    .q_susp   (q_susp),
    .q_res    (q_res),
    .q_rst    (q_rst),
    .q_hsen   (q_hsen)
  );

  usb_pwr_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .host         (host),
    .susp_b       (q_susp),
    .res_b        (q_res),
    .rst_b        (q_rst),
    .phys_b       (q_phys),
    .busy         (xfer_busy),
    .resume_det   (bus_resume_det),
    .irq_en       (irq_resume_en),
    .st           (st),
    .wake         (wake),
    .rst_enter    (rst_enter),
    .frame_en     (frame_en),
    .sched_en     (sched_en),
    .sof_en       (sof_en),
    .drive_resume (drive_resume),
    .drive_reset  (drive_reset),
    .phy_lowpwr   (phy_lowpwr),
    .irq          (resume_irq)
  );

  usb_pwr_hsneg u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_reset  (st == ST_RESET),
    .rst_enter (rst_enter),
    .hsen      (q_hsen),
    .done      (chirp_done),
    .result    (chirp_hs),
    .negotiate (hs_negotiate),
    .hs_mode   (hs_mode)
  );

  always_comb begin
    pwr_rdata          = '0;
    pwr_rdata[PB_PHYS] = q_phys;
    pwr_rdata[PB_SUSP] = q_susp;
    pwr_rdata[PB_RES]  = q_res;
    pwr_rdata[PB_RST]  = q_rst;
    pwr_rdata[PB_HS]   = hs_mode;
    pwr_rdata[PB_HSEN] = q_hsen;
  end

  AST_OFF_WHEN_NOT_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    !host |=> !(frame_en || sched_en || sof_en || drive_resume || drive_reset || phy_lowpwr)); // R1
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    resume_irq |-> $past(irq_resume_en)); // R6
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    resume_irq |=> !resume_irq); // R6
  AST_SPARE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_rdata[PWR_W-1:PB_USED] == {SPARE_W{1'b0}}); // R2
endmodule

// File: tb/tb_usb_host_pwr_ctl.sv
`timescale 1ns/1ps
module tb_usb_host_pwr_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic role_dev = 1'b0, sess_on = 1'b0, pwr_wr = 1'b0;
  logic [7:0] pwr_wdata = 8'h00;
  logic [7:0] pwr_rdata;
  logic irq_resume_en = 1'b0, xfer_busy = 1'b0, bus_resume_det = 1'b0;
  logic chirp_done = 1'b0, chirp_hs = 1'b0;
  logic frame_en, sched_en, sof_en, drive_resume, drive_reset, phy_lowpwr;
  logic hs_negotiate, resume_irq;

  always #2 clk = ~clk;

  usb_host_pwr_ctl dut (
    .clk(clk), .rst_n(rst_n), .role_dev(role_dev), .sess_on(sess_on),
    .pwr_wr(pwr_wr), .pwr_wdata(pwr_wdata), .pwr_rdata(pwr_rdata),
    .irq_resume_en(irq_resume_en), .xfer_busy(xfer_busy),
    .bus_resume_det(bus_resume_det), .chirp_done(chirp_done), .chirp_hs(chirp_hs),
    .frame_en(frame_en), .sched_en(sched_en), .sof_en(sof_en),
    .drive_resume(drive_resume), .drive_reset(drive_reset),
    .phy_lowpwr(phy_lowpwr), .hs_negotiate(hs_negotiate), .resume_irq(resume_irq)
  );

  // observed word: {rdata, frame, sched, sof, drv_res, drv_rst, lowpwr, hsneg, irq}
  typedef struct { int due; int req; logic [15:0] val; } exp_t;
  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] obs();
    return {pwr_rdata, frame_en, sched_en, sof_en, drive_resume,
            drive_reset, phy_lowpwr, hs_negotiate, resume_irq};
  endfunction

  task automatic push(input int r, input int d, input logic [15:0] v);
    exp_t e;
    e.due = cyc + d; e.req = r; e.val = v;
    q.push_back(e);
  endtask

  // monitor: compare each expectation in its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.due < cyc || obs() !== e.val) begin
        errors++;
        $display("FAIL R%0d cyc %0d actual %h expected %h", e.req, cyc, obs(), e.val);
      end
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); pwr_wr = 1'b1; pwr_wdata = d;
    @(negedge clk); pwr_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push(1, 1, 16'h0000);                     // R1 reset state
    settle();
    @(negedge clk); role_dev = 1'b1; sess_on = 1'b1;
    push(1, 1, 16'h0000); push(1, 2, 16'h0000); // R1 peripheral role stays off
    settle();
    @(negedge clk); role_dev = 1'b0;
    push(1, 1, 16'h00E0);                     // R1 host role starts
    settle();
    wr(8'hD1); push(2, 1, 16'h01E0);          // R2 spare and status bits not writable
    settle();
    wr(8'h00); settle();
    xfer_busy = 1'b1;
    wr(8'h03); push(3, 1, 16'h0380);          // R3 drain while busy
    settle(); push(3, 1, 16'h0380);           // R3 still draining
    settle();
    @(negedge clk); xfer_busy = 1'b0;
    push(4, 1, 16'h0304);                     // R3 R4 suspended, PHY low power
    settle();
    irq_resume_en = 1'b1;
    @(negedge clk); bus_resume_det = 1'b1;
    push(6, 1, 16'h0511); push(6, 2, 16'h0510); // R6 wake-up and interrupt pulse
    @(negedge clk); bus_resume_det = 1'b0;
    settle();
    wr(8'h01); push(5, 1, 16'h01E0);          // R5 resume cleared, enables back
    settle();
    wr(8'h02); push(4, 1, 16'h0200);          // R4 suspended without PHY low power
    settle();
    irq_resume_en = 1'b0;
    @(negedge clk); bus_resume_det = 1'b1; pwr_wr = 1'b1; pwr_wdata = 8'h00;
    push(7, 1, 16'h0010); push(7, 2, 16'h00E0); // R7 software write wins, no irq
    @(negedge clk); bus_resume_det = 1'b0; pwr_wr = 1'b0;
    settle();
    wr(8'h28); push(9, 1, 16'h280A);          // R9 reset with negotiation
    settle();
    @(negedge clk); chirp_done = 1'b1; chirp_hs = 1'b1;
    push(9, 1, 16'h3808);                     // R9 chirp result recorded
    @(negedge clk); chirp_done = 1'b0; chirp_hs = 1'b0;
    settle();
    wr(8'h20); push(11, 1, 16'h30E0);         // R11 reset released
    settle();
    wr(8'h28); push(10, 1, 16'h280A);         // R10 status cleared at reset start
    settle();
    @(negedge clk); chirp_done = 1'b1;
    push(9, 1, 16'h2808);                     // R9 full-speed result
    @(negedge clk); chirp_done = 1'b0;
    settle();
    wr(8'h20); push(11, 1, 16'h20E0);         // R11
    settle();
    wr(8'h02); push(4, 1, 16'h0200); settle();
    wr(8'h0A); push(8, 1, 16'h0808);          // R8 reset during suspend clears request
    settle();
    wr(8'h00); push(11, 1, 16'h00E0); settle();
    wr(8'h0C); push(8, 1, 16'h0C08);          // R8 reset over resume
    settle();
    wr(8'h00); settle();
    @(negedge clk); bus_resume_det = 1'b1;
    push(6, 1, 16'h00E0); push(6, 2, 16'h00E0); // R6 wake ignored outside suspend
    @(negedge clk); bus_resume_det = 1'b0;
    settle();
    @(negedge clk); sess_on = 1'b0;
    push(1, 1, 16'h0000);                     // R1 session ends
    settle();
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    done_flag = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL R1 watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule